// File: doc/BRIEF.md
# Shunt Overcurrent Guard

This block turns two digitized comparator flags, both taken from the voltage across the inverter's current-sense shunt, into timed protection decisions. The flags come from two thresholds. The limit flag uses the lower threshold, nominally 0.65 V. The trip flag uses the higher threshold, nominally 1.0 V. Both flags are synchronous to the block clock.

**Current-limit level.** A blanking filter qualifies the limit flag. The result is an active-high current-limit level. It can be looped back to a high-side shutdown input so that current is limited cycle by cycle.

**Overcurrent protection.** The same kind of blanking filter qualifies the trip flag. Once it qualifies, the block enters protection. In protection it raises a low-side gate inhibit and a fault request together. The block leaves protection only after a hold window has run out. That window is counted from the moment the trip flag falls back low, not from the moment the trip occurred.

**Timing.** All timing is counted in clock cycles. The counts are derived from the clock frequency in MHz (`CLK_MHZ`) and from nanosecond parameters:

- `BLANK_NS`: blanking time, nominal 2 µs.
- `HOLD_NS`: hold time, nominal 25 µs.

Each is converted to cycles, rounded up, with a minimum of one. The results are called BLANK_CYC and HOLD_CYC below.

**Interface.** All pins are plain control levels. There is no streaming data path, so there is no handshake at the edge of the block.

Top module: `shunt_guard`

## Requirements
- R1: While reset is low, and on the first cycles after it is released with both flags low, `cur_limit_o`, `prot_active_o` and `ls_inhibit_o` are all 0.
- R2: `cur_limit_o` goes to 1 right after the clock edge that samples `lim_flag_i` high for the BLANK_CYC-th consecutive time. It stays 1 while the flag stays high.
- R3: A high run of `lim_flag_i` shorter than BLANK_CYC samples leaves `cur_limit_o` at 0. A low sample clears the run, so the next high run must again reach BLANK_CYC samples.
- R4: `cur_limit_o` returns to 0 right after the first edge that samples `lim_flag_i` low.
- R5: Protection starts one cycle after the trip flag qualifies, that is, right after the edge that follows the BLANK_CYC-th consecutive high sample of `trip_flag_i`. `prot_active_o` and `ls_inhibit_o` rise in that same cycle and are always equal.
- R6: A high run of `trip_flag_i` shorter than BLANK_CYC samples never starts protection.
- R7: Protection holds for as long as `trip_flag_i` is high. After the first edge that samples it low, protection drops right after the HOLD_CYC-th following edge, provided the flag stays low throughout.
- R8: If `trip_flag_i` is sampled high during the hold window, the hold count is abandoned. It starts again from zero at the next low sample. A short re-assertion of this kind does not need blanking to extend protection.
- R9: The two paths are independent. A trip event never changes `cur_limit_o`, and the limit path keeps working while protection is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; all counting is in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lim_flag_i | input | 1 | Shunt voltage above the lower (limit) threshold |
| trip_flag_i | input | 1 | Shunt voltage above the higher (trip) threshold |
| cur_limit_o | output | 1 | Qualified current-limit level, active high |
| prot_active_o | output | 1 | Protection in force; requests the fault output |
| ls_inhibit_o | output | 1 | Forces all low-side gates off |

## Verification
The assertions assume that both flags are already synchronous to `clk_i` and that they change only between clock edges. The bench therefore drives them on the falling edge.

One corner is left unexercised on purpose. That is a trip flag that qualifies and then drops on the very next sample, because this pushes the start of the hold window out by one cycle. To keep clear of it, every qualifying trip pulse in the stimulus is held well past BLANK_CYC+1 samples.

The short pulses and the re-assertions inside the hold window stay below BLANK_CYC. They test the rejection and restart rules without qualifying a second time.

// File: rtl/shg_pkg.sv
package shg_pkg;

  typedef enum logic [1:0] {
    PROT_IDLE    = 2'b00,
    PROT_TRIPPED = 2'b01,
    PROT_HOLD    = 2'b10
  } prot_state_e;

  // Converts a duration in ns to clock cycles, rounding up, never below one.
  function automatic int unsigned ns_to_cyc(int unsigned mhz, int unsigned ns);
    int unsigned c;
    c = (mhz * ns + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/shg_blank_qual.sv
module shg_blank_qual #(
  parameter int unsigned BLANK_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic qual_o
);

  localparam int unsigned CW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

  logic [CW-1:0] run_q;
  logic          qual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      qual_q <= 1'b0;
    end else if (!flag_i) begin
      run_q  <= '0;
      qual_q <= 1'b0;
    end else if (!qual_q) begin
      if (run_q == LAST) qual_q <= 1'b1;
      else               run_q  <= run_q + 1'b1;
    end
  end

  assign qual_o = qual_q;

  // R2
  qual_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qual_o) |-> $past(flag_i));

  // R4
  qual_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(flag_i) |-> !qual_o);

  // R3
  run_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= LAST);

endmodule

// File: rtl/shg_prot_ctrl.sv
module shg_prot_ctrl
  import shg_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_flag_i,
  input  logic trip_qual_i,
  output logic active_o
);

  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYC);
  localparam logic [HW-1:0] ONE      = HW'(1);

  prot_state_e   state_q, state_d;
  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      PROT_IDLE: begin
        cnt_d = '0;
        if (trip_qual_i) state_d = PROT_TRIPPED;
      end
      PROT_TRIPPED: begin
        cnt_d = '0;
        if (!trip_flag_i) begin
          state_d = PROT_HOLD;
          cnt_d   = ONE;
        end
      end
      PROT_HOLD: begin
        if (trip_flag_i) begin
          state_d = PROT_TRIPPED;
          cnt_d   = '0;
        end else if (cnt_q == HOLD_END) begin
          state_d = PROT_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = PROT_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PROT_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign active_o = (state_q != PROT_IDLE);

  // R5
  qual_enters_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_qual_i |=> active_o);

  // R7
  high_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && trip_flag_i) |=> active_o);

  // R7
  release_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> !$past(trip_flag_i));

  // R8
  hold_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= HOLD_END);

endmodule

// File: rtl/shunt_guard.sv
module shunt_guard
  import shg_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned BLANK_NS = 2000,
  parameter int unsigned HOLD_NS  = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lim_flag_i,
  input  logic trip_flag_i,
  output logic cur_limit_o,
  output logic prot_active_o,
  output logic ls_inhibit_o
);

  localparam int unsigned BLANK_CYC = ns_to_cyc(CLK_MHZ, BLANK_NS);
  localparam int unsigned HOLD_CYC  = ns_to_cyc(CLK_MHZ, HOLD_NS);
  localparam int unsigned N_CH      = 2;   // channel 0: limit, channel 1: trip

  logic [N_CH-1:0] flag_vec;
  logic [N_CH-1:0] qual_vec;
  logic            prot_on;

  assign flag_vec = {trip_flag_i, lim_flag_i};

  for (genvar g = 0; g < N_CH; g++) begin : g_qual
    shg_blank_qual #(.BLANK_CYC(BLANK_CYC)) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flag_i (flag_vec[g]),
      .qual_o (qual_vec[g])
    );
  end

  shg_prot_ctrl #(.HOLD_CYC(HOLD_CYC)) u_prot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trip_flag_i (trip_flag_i),
    .trip_qual_i (qual_vec[1]),
    .active_o    (prot_on)
  );

  assign cur_limit_o   = qual_vec[0];
  assign prot_active_o = prot_on;
  assign ls_inhibit_o  = prot_on;

  // R9
  limit_follows_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cur_limit_o) |-> $past(lim_flag_i));

endmodule

// File: tb/shunt_guard_tb_top.sv
module shunt_guard_tb_top;

  localparam int B = 10;   // 80 ns at 125 MHz
  localparam int H = 25;   // 200 ns at 125 MHz

  typedef struct {
    bit    ocl;
    bit    prot;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lim = 1'b0;
  logic trip = 1'b0;
  logic ocl_o, act_o, inh_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  exp_t sb_q[$];

  int lim_run = 0, trip_run = 0, low_run = 0;
  bit qt = 1'b0, prot_e = 1'b0, qt_old;

  always #4 clk = ~clk;

  shunt_guard #(.CLK_MHZ(125), .BLANK_NS(80), .HOLD_NS(200)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .lim_flag_i    (lim),
    .trip_flag_i   (trip),
    .cur_limit_o   (ocl_o),
    .prot_active_o (act_o),
    .ls_inhibit_o  (inh_o)
  );

  task automatic check(bit act, bit exp, string req, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s t=%0t actual=%0b expected=%0b", req, what, $time, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues what the outputs must show after the next edge.
  task automatic cyc(bit l, bit t, string req);
    exp_t e;
    @(negedge clk);
    lim  = l;
    trip = t;
    lim_run  = l ? lim_run + 1 : 0;
    qt_old   = qt;
    trip_run = t ? trip_run + 1 : 0;
    qt       = (trip_run >= B);
    low_run  = t ? 0 : low_run + 1;
    if (qt_old) prot_e = 1'b1;
    else if (prot_e && !t && low_run > H) prot_e = 1'b0;
    e.ocl  = (lim_run >= B);
    e.prot = prot_e;
    e.req  = req;
    sb_q.push_back(e);
  endtask

  // Monitor: pops one expected item per clock, away from the edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(ocl_o, e.ocl,  e.req, "cur_limit_o");
        check(act_o, e.prot, e.req, "prot_active_o");
        check(inh_o, e.prot, e.req, "ls_inhibit_o");
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    // R1: outputs low during reset
    check(ocl_o, 1'b0, "R1", "cur_limit_o in reset");
    check(act_o, 1'b0, "R1", "prot_active_o in reset");
    check(inh_o, 1'b0, "R1", "ls_inhibit_o in reset");
    @(negedge clk);
    rst_n = 1'b1;

    repeat (3) cyc(0, 0, "R1");

    // R3: short limit runs, run cleared by a single low sample
    repeat (B-1) cyc(1, 0, "R3");
    cyc(0, 0, "R3");
    repeat (B-1) cyc(1, 0, "R3");
    repeat (3) cyc(0, 0, "R3");

    // R2 then R4
    repeat (20) cyc(1, 0, "R2");
    repeat (4) cyc(0, 0, "R4");

    // R6: short trip pulses
    repeat (B-1) cyc(0, 1, "R6");
    repeat (3) cyc(0, 0, "R6");
    repeat (5) cyc(0, 1, "R6");
    repeat (4) cyc(0, 0, "R6");

    // R5 entry, R7 hold and release
    repeat (15) cyc(0, 1, "R5");
    repeat (H + 10) cyc(0, 0, "R7");

    // R9: trip leaves the limit path alone, limit path works during hold
    repeat (15) cyc(0, 1, "R9");
    repeat (14) cyc(1, 0, "R9");
    repeat (H + 5) cyc(0, 0, "R9");

    // R8: re-assertion during hold restarts the window
    repeat (15) cyc(0, 1, "R8");
    repeat (10) cyc(0, 0, "R8");
    repeat (3) cyc(0, 1, "R8");
    repeat (H + 10) cyc(0, 0, "R8");

    repeat (4) @(posedge clk);
    #3;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule